// File: doc/BRIEF.md
# Dual-Mode Host Register Bridge

This block is a synchronous slave on an external host bus. It gives a microcontroller access to a small internal bank of 32-bit control and status registers over a data path that is only 8 or 16 bits wide. A strap input fixes the bus width. A second static input picks one of two signalling conventions. In the Intel style, separate active-low read and write strobes are used and the block answers with an active-high ready. In the Motorola style, an active-low transfer start and a read/write level are used and the block answers with an active-low acknowledge. Every strobe is sampled on the rising edge of the host clock.

Each 32-bit register is moved as a whole word, in slices that the low address bits select. A write to a lower slice only fills a holding register. A write to the most significant slice commits the assembled word. A read of slice 0 takes a snapshot of the whole register, and the later slices of that read are served from the snapshot, so the host always sees one coherent value. The acknowledge follows a fixed internal latency. If the internal access is slow, a timeout forces the acknowledge. The acknowledge stays up until chip select is released.

The register model has a status register at index 0, an interrupt-enable register at index 1 and scratch registers above them. Event inputs set status bits, and writing 1 to a status bit clears it. The interrupt output is high while any enabled status bit is set.

Top module: `hreg_bridge`

## Requirements
- R1: After reset, rdy is 0, ack_n is 1, irq is 0, dout_oe is 0 and every register reads as zero.
- R2: With bus16=0, addr[1:0] selects byte slice 0 to 3 (slice 0 is bits 7:0) and addr[14:2] is the register index. With bus16=1, addr[0] selects halfword 0 or 1 (halfword 0 is bits 15:0) and addr[14:1] is the index.
- R3: A write to any slice below the top one (byte 3 or halfword 1) never changes a register. A write to the top slice commits that slice together with the held lower slices as one 32-bit word.
- R4: A read of slice 0 captures the whole register. Reads of higher slices return bytes or halfwords of the most recent capture, even if the register has changed since then.
- R5: When the internal access finishes early, the acknowledge becomes visible exactly 6 clock edges after the edge that samples the start of the access. It is never later than 22 edges.
- R6: The acknowledge stays asserted while cs_n stays low. It drops on the first edge that samples cs_n high, and no new access starts before that edge.
- R7: With moto_mode=0, an access starts when cs_n=0 and either rd_n=0 or wr_n=0, where wr_n=0 means a write. The acknowledge is rdy=1, and ack_n stays 1.
- R8: With moto_mode=1, an access starts when cs_n=0 and ts_n=0, where rnw=1 means a read. The acknowledge is ack_n=0, and rdy stays 0.
- R9: The status register at index 0 gets a bit set by a 1 on stat_ev. Writing a word with 1 in a bit position clears that status bit.
- R10: irq is 1 exactly when some bit is set both in the status register and in the enable register at index 1.
- R11: An index of 8 or more reads as zero, and a write to it changes no register.
- R12: While a read is acknowledged, dout_oe=1 and dout carries the selected slice, with the upper byte zero in 8-bit mode. Otherwise dout_oe=0 and dout=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host interface clock |
| rst | input | 1 | Synchronous active-high reset |
| bus16 | input | 1 | Strap: 1 selects a 16-bit data bus, 0 an 8-bit bus |
| moto_mode | input | 1 | 1 selects Motorola-style signalling, 0 Intel-style |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 15 | Host address: register index and slice |
| wr_n | input | 1 | Intel-style active-low write strobe |
| rd_n | input | 1 | Intel-style active-low read strobe |
| ts_n | input | 1 | Motorola-style active-low transfer start |
| rnw | input | 1 | Motorola-style direction, 1 = read |
| din | input | 16 | Host write data (bits 7:0 used in 8-bit mode) |
| dout | output | 16 | Host read data |
| dout_oe | output | 1 | High while read data is driven |
| rdy | output | 1 | Intel-style ready, active high |
| ack_n | output | 1 | Motorola-style transfer acknowledge, active low |
| stat_ev | input | 32 | Event pulses that set status bits |
| irq | output | 1 | Interrupt request, active high |

## Verification
On every cycle, the assertions check the acknowledge timing: no acknowledge before the minimum latency, the wait counter never past the timeout, the acknowledge held while chip select is low and released once it goes high. They also check that the unused handshake output stays idle in each signalling mode, that a register or the status word changes only through a commit or an event, and that a read of a higher slice leaves the snapshot alone. Only the bench scenarios can show the data results: how slices assemble into committed words in both widths, that a partial write leaves the register unchanged, that a read stays coherent while a status bit changes in the middle of it, write-one-to-clear behaviour, the interrupt following status and enable, and out-of-range indices reading zero.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

    localparam int HA_W   = 15;
    localparam int HD_W   = 16;
    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        BS_IDLE,
        BS_WAIT,
        BS_ACK
    } bus_state_e;

    typedef struct packed {
        logic            is_wr;
        logic [HA_W-1:0] addr;
        logic [HD_W-1:0] wdata;
    } xfer_t;

    // slice number carried by the low address bits
    function automatic logic [1:0] slice_of(input logic [HA_W-1:0] a, input logic wide);
        logic [1:0] s;
        s = wide ? {1'b0, a[0]} : a[1:0];
        return s;
    endfunction

    // slice whose write commits the assembled word
    function automatic logic [1:0] last_slice(input logic wide);
        logic [1:0] s;
        s = wide ? 2'd1 : 2'd3;
        return s;
    endfunction

    // register index above the slice bits
    function automatic logic [HA_W-1:0] index_of(input logic [HA_W-1:0] a, input logic wide);
        logic [HA_W-1:0] i;
        i = wide ? {1'b0, a[HA_W-1:1]} : {2'b00, a[HA_W-1:2]};
        return i;
    endfunction

    // slice of a word as it appears on the host data bus
    function automatic logic [HD_W-1:0] pick_slice(input logic [WORD_W-1:0] w,
                                                   input logic [1:0] s, input logic wide);
        logic [HD_W-1:0] r;
        if (wide) begin
            r = s[0] ? w[31:16] : w[15:0];
        end else begin
            case (s)
                2'd0:    r = {8'h00, w[7:0]};
                2'd1:    r = {8'h00, w[15:8]};
                2'd2:    r = {8'h00, w[23:16]};
                default: r = {8'h00, w[31:24]};
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/hreg_bus_front.sv
module hreg_bus_front
    import hreg_pkg::*;
#(
    parameter int MIN_LAT = 6,
    parameter int MAX_LAT = 22
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            moto_mode,
    input  logic            cs_n,
    input  logic            wr_n,
    input  logic            rd_n,
    input  logic            ts_n,
    input  logic            rnw,
    input  logic [HA_W-1:0] addr,
    input  logic [HD_W-1:0] din,
    input  logic            acc_done,
    output xfer_t           xfer,
    output logic            start,
    output logic            acked,
    output logic            cur_wr,
    output logic            rdy,
    output logic            ack_n
);

    localparam int CNT_W = $clog2(MAX_LAT + 1);

    bus_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             req_v;

    always_comb begin
        xfer.addr  = addr;
        xfer.wdata = din;
        if (moto_mode) begin
            req_v      = !cs_n && !ts_n;
            xfer.is_wr = !rnw;
        end else begin
            req_v      = !cs_n && (!wr_n || !rd_n);
            xfer.is_wr = !wr_n;
        end
    end

    assign start = (state_q == BS_IDLE) && req_v;
    assign acked = (state_q == BS_ACK);
    assign rdy   = !moto_mode && acked;
    assign ack_n = !(moto_mode && acked);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= BS_IDLE;
            cnt_q   <= '0;
            cur_wr  <= 1'b0;
        end else begin
            case (state_q)
                BS_IDLE: begin
                    if (start) begin
                        state_q <= BS_WAIT;
                        cnt_q   <= CNT_W'(1);
                        cur_wr  <= xfer.is_wr;
                    end
                end
                BS_WAIT: begin
                    if ((cnt_q >= CNT_W'(MIN_LAT) && acc_done) || cnt_q >= CNT_W'(MAX_LAT))
                        state_q <= BS_ACK;
                    else
                        cnt_q <= cnt_q + CNT_W'(1);
                end
                BS_ACK: begin
                    if (cs_n) state_q <= BS_IDLE;
                end
                default: state_q <= BS_IDLE;
            endcase
        end
    end

    // R5: the wait counter never passes the timeout limit
    p_ack_timeout_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == BS_WAIT) |-> (cnt_q <= CNT_W'(MAX_LAT)));

    // R5: no acknowledge before the minimum latency
    p_ack_min_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == BS_WAIT && cnt_q < CNT_W'(MIN_LAT)) |=> (state_q != BS_ACK));

    // R6: acknowledge held while selected, dropped once deselected
    p_ack_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == BS_ACK && !cs_n) |=> (state_q == BS_ACK));
    p_ack_release_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == BS_ACK && cs_n) |=> (state_q == BS_IDLE));

    // R7 and R8: the handshake of the unused style stays idle
    p_intel_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !moto_mode |-> ack_n);
    p_moto_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        moto_mode |-> !rdy);

endmodule

// File: rtl/hreg_slicer.sv
module hreg_slicer
    import hreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              start,
    input  xfer_t             xfer,
    input  logic [WORD_W-1:0] rf_rdata,
    output logic              commit_en,
    output logic [WORD_W-1:0] commit_word,
    output logic [HD_W-1:0]   rd_slice
);

    logic [23:0]       hold_q;
    logic [WORD_W-1:0] snap_q;
    logic [HD_W-1:0]   rd_q;
    logic [1:0]        s;
    logic              top;
    logic [WORD_W-1:0] src_word;

    assign s           = slice_of(xfer.addr, wide);
    assign top         = (s == last_slice(wide));
    assign commit_en   = start && xfer.is_wr && top;
    assign commit_word = wide ? {xfer.wdata, hold_q[15:0]}
                              : {xfer.wdata[7:0], hold_q[23:0]};
    assign src_word    = (s == 2'd0) ? rf_rdata : snap_q;
    assign rd_slice    = rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            snap_q <= '0;
            rd_q   <= '0;
        end else if (start) begin
            if (xfer.is_wr) begin
                if (!top) begin
                    if (wide) begin
                        hold_q[15:0] <= xfer.wdata;
                    end else begin
                        case (s)
                            2'd0:    hold_q[7:0]   <= xfer.wdata[7:0];
                            2'd1:    hold_q[15:8]  <= xfer.wdata[7:0];
                            default: hold_q[23:16] <= xfer.wdata[7:0];
                        endcase
                    end
                end
            end else begin
                if (s == 2'd0) snap_q <= rf_rdata;
                rd_q <= pick_slice(src_word, s, wide);
            end
        end
    end

    // R4: reading a higher slice leaves the snapshot untouched
    p_snap_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (start && !xfer.is_wr && s != 2'd0) |=> $stable(snap_q));

endmodule

// File: rtl/hreg_regfile.sv
module hreg_regfile
    import hreg_pkg::*;
#(
    parameter int NREGS   = 8,
    parameter int ACC_LAT = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              wr_en,
    input  logic [HA_W-1:0]   idx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] ev,
    output logic [WORD_W-1:0] rdata,
    output logic              done,
    output logic              irq
);

    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;
    localparam int LAT_W = $clog2(ACC_LAT + 1);

    logic [WORD_W-1:0] regs_q [NREGS];
    logic [LAT_W-1:0]  lat_q;
    logic              in_range;

    assign in_range = (idx < HA_W'(NREGS));
    assign rdata    = in_range ? regs_q[idx[IDX_W-1:0]] : '0;
    assign done     = (lat_q == '0);
    assign irq      = |(regs_q[0] & regs_q[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NREGS; k++) regs_q[k] <= '0;
        end else begin
            for (int k = 0; k < NREGS; k++) begin
                if (k == 0) begin
                    if (wr_en && idx == HA_W'(0))
                        regs_q[0] <= (regs_q[0] & ~wdata) | ev;
                    else
                        regs_q[0] <= regs_q[0] | ev;
                end else if (wr_en && idx == HA_W'(k)) begin
                    regs_q[k] <= wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= '0;
        else if (req)
            lat_q <= LAT_W'(ACC_LAT);
        else if (lat_q != '0)
            lat_q <= lat_q - LAT_W'(1);
    end

    // R9: status changes only through a commit or an event
    p_status_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && ev == '0) |=> $stable(regs_q[0]));

    // R3: without a commit no ordinary register moves
    for (genvar g = 1; g < NREGS; g++) begin : g_keep
        p_no_commit_r3: assert property (@(posedge clk) disable iff (rst)
            !wr_en |=> $stable(regs_q[g]));
    end

endmodule

// File: rtl/hreg_bridge.sv
module hreg_bridge
    import hreg_pkg::*;
#(
    parameter int NREGS   = 8,
    parameter int MIN_LAT = 6,
    parameter int MAX_LAT = 22,
    parameter int ACC_LAT = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus16,
    input  logic        moto_mode,
    input  logic        cs_n,
    input  logic [14:0] addr,
    input  logic        wr_n,
    input  logic        rd_n,
    input  logic        ts_n,
    input  logic        rnw,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        dout_oe,
    output logic        rdy,
    output logic        ack_n,
    input  logic [31:0] stat_ev,
    output logic        irq
);

    xfer_t             xfer;
    logic              start;
    logic              acked;
    logic              cur_wr;
    logic              acc_done;
    logic              commit_en;
    logic [WORD_W-1:0] commit_word;
    logic [WORD_W-1:0] rf_rdata;
    logic [HD_W-1:0]   rd_slice;

    hreg_bus_front #(
        .MIN_LAT (MIN_LAT),
        .MAX_LAT (MAX_LAT)
    ) u_front (
        .clk       (clk),
        .rst       (rst),
        .moto_mode (moto_mode),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .ts_n      (ts_n),
        .rnw       (rnw),
        .addr      (addr),
        .din       (din),
        .acc_done  (acc_done),
        .xfer      (xfer),
        .start     (start),
        .acked     (acked),
        .cur_wr    (cur_wr),
        .rdy       (rdy),
        .ack_n     (ack_n)
    );

    hreg_slicer u_slicer (
        .clk         (clk),
        .rst         (rst),
        .wide        (bus16),
        .start       (start),
        .xfer        (xfer),
        .rf_rdata    (rf_rdata),
        .commit_en   (commit_en),
        .commit_word (commit_word),
        .rd_slice    (rd_slice)
    );

    hreg_regfile #(
        .NREGS   (NREGS),
        .ACC_LAT (ACC_LAT)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (start),
        .wr_en (commit_en),
        .idx   (index_of(xfer.addr, bus16)),
        .wdata (commit_word),
        .ev    (stat_ev),
        .rdata (rf_rdata),
        .done  (acc_done),
        .irq   (irq)
    );

    assign dout_oe = acked && !cur_wr;
    assign dout    = dout_oe ? rd_slice : '0;

    // R12: read data is only driven during an acknowledged read
    p_dout_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !acked |-> (dout == '0 && !dout_oe));

endmodule

// File: tb/hreg_bridge_tb.sv
module hreg_bridge_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus16 = 1'b0;
    logic        moto_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic [14:0] addr = '0;
    logic        wr_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        ts_n = 1'b1;
    logic        rnw = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        dout_oe;
    logic        rdy;
    logic        ack_n;
    logic [31:0] stat_ev = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    logic [31:0] m_reg [8];
    logic [23:0] m_hold = '0;
    logic [31:0] m_snap = '0;

    always #2 clk = ~clk;

    hreg_bridge u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus16     (bus16),
        .moto_mode (moto_mode),
        .cs_n      (cs_n),
        .addr      (addr),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .ts_n      (ts_n),
        .rnw       (rnw),
        .din       (din),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .rdy       (rdy),
        .ack_n     (ack_n),
        .stat_ev   (stat_ev),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (running) begin
            chk(irq == |(m_reg[0] & m_reg[1]), "R10 irq follows status and enable",
                irq, |(m_reg[0] & m_reg[1]));
            if (moto_mode) chk(rdy == 1'b0, "R8 rdy idle", rdy, 0);
            else           chk(ack_n == 1'b1, "R7 ack_n idle", ack_n, 1);
        end
    end

    function automatic logic [15:0] slice_val(input logic [31:0] w, input int sl, input bit wide);
        if (wide) return (sl == 1) ? w[31:16] : w[15:0];
        return {8'h00, w[8*sl +: 8]};
    endfunction

    // behavioural model of one access, applied at the start edge
    task automatic model_apply(input bit wr, input int idx, input int sl,
                               input logic [15:0] data, output logic [15:0] exp);
        logic [31:0] cur;
        logic [31:0] w;
        int top;
        top = bus16 ? 1 : 3;
        cur = (idx < 8) ? m_reg[idx] : 32'h0;
        exp = '0;
        if (wr) begin
            if (sl == top) begin
                w = bus16 ? {data, m_hold[15:0]} : {data[7:0], m_hold[23:0]};
                if (idx == 0)     m_reg[0] = m_reg[0] & ~w;
                else if (idx < 8) m_reg[idx] = w;
            end else if (bus16) begin
                m_hold[15:0] = data;
            end else begin
                m_hold[8*sl +: 8] = data[7:0];
            end
        end else begin
            if (sl == 0) m_snap = cur;
            exp = slice_val((sl == 0) ? cur : m_snap, sl, bus16);
        end
    endtask

    task automatic xfer(input bit wr, input int idx, input int sl,
                        input logic [15:0] data, input string rq);
        logic [15:0] exp;
        int lat;
        bit got;
        @(negedge clk);
        addr = bus16 ? 15'(idx * 2 + sl) : 15'(idx * 4 + sl);
        din  = data;
        cs_n = 1'b0;
        if (moto_mode) begin
            ts_n = 1'b0;
            rnw  = !wr;
        end else if (wr) begin
            wr_n = 1'b0;
        end else begin
            rd_n = 1'b0;
        end
        @(posedge clk);
        model_apply(wr, idx, sl, data, exp);
        lat = 0;
        got = 1'b0;
        while (!got && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            got = moto_mode ? !ack_n : rdy;
        end
        chk(lat == 6, "R5 acknowledge latency", lat, 6);
        if (wr) begin
            chk(dout_oe == 1'b0, "R12 no drive on write", dout_oe, 0);
        end else begin
            chk(dout_oe == 1'b1, "R12 drive on read", dout_oe, 1);
            chk(dout == exp, rq, dout, exp);
        end
        @(posedge clk);
        @(negedge clk);
        got = moto_mode ? !ack_n : rdy;
        chk(got, "R6 acknowledge held while selected", got, 1);
        cs_n = 1'b1;
        ts_n = 1'b1;
        wr_n = 1'b1;
        rd_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        got = moto_mode ? !ack_n : rdy;
        chk(!got, "R6 acknowledge released", got, 0);
        chk(dout == 16'h0 && !dout_oe, "R12 bus quiet after access", dout, 0);
    endtask

    task automatic pulse_ev(input logic [31:0] v);
        @(negedge clk);
        stat_ev = v;
        @(posedge clk);
        m_reg[0] = m_reg[0] | v;
        @(negedge clk);
        stat_ev = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 8; k++) m_reg[k] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(rdy == 1'b0, "R1 rdy after reset", rdy, 0);
        chk(ack_n == 1'b1, "R1 ack_n after reset", ack_n, 1);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(dout_oe == 1'b0, "R1 dout_oe after reset", dout_oe, 0);
        running = 1'b1;
        xfer(1'b0, 5, 0, 16'h0, "R1 register zero after reset");

        // R2 R3 R7: Intel style, byte bus, partial writes then commit
        bus16 = 1'b0; moto_mode = 1'b0;
        xfer(1'b1, 2, 0, 16'h00D4, "R3 write byte 0");
        xfer(1'b1, 2, 1, 16'h00C3, "R3 write byte 1");
        xfer(1'b1, 2, 2, 16'h00B2, "R3 write byte 2");
        for (int s = 0; s < 4; s++) xfer(1'b0, 2, s, 16'h0, "R3 partial write left register unchanged");
        xfer(1'b1, 2, 3, 16'h00A1, "R3 commit byte 3");
        for (int s = 0; s < 4; s++) xfer(1'b0, 2, s, 16'h0, "R2 byte slice readback");

        // R2 R7: Intel style, halfword bus
        bus16 = 1'b1;
        xfer(1'b1, 3, 0, 16'h5678, "R2 write half 0");
        xfer(1'b1, 3, 1, 16'h1234, "R2 commit half 1");
        xfer(1'b0, 3, 0, 16'h0, "R2 halfword 0 readback");
        xfer(1'b0, 3, 1, 16'h0, "R2 halfword 1 readback");
        xfer(1'b1, 4, 1, 16'h9ABC, "R3 commit reuses held half");
        xfer(1'b0, 4, 0, 16'h0, "R3 held half committed");
        xfer(1'b0, 4, 1, 16'h0, "R3 top half committed");

        // R8 R10: Motorola style, enable and status event
        moto_mode = 1'b1;
        xfer(1'b1, 1, 0, 16'h8001, "R8 write enable low half");
        xfer(1'b1, 1, 1, 16'h0000, "R8 commit enable");
        pulse_ev(32'h0000_0001);
        xfer(1'b0, 0, 0, 16'h0, "R9 status event visible");
        xfer(1'b0, 1, 0, 16'h0, "R8 enable readback");

        // R4: coherent read while status changes, byte bus
        bus16 = 1'b0;
        xfer(1'b0, 0, 0, 16'h0, "R4 slice 0 snapshot");
        pulse_ev(32'h0100_0000);
        xfer(1'b0, 0, 3, 16'h0, "R4 top byte from snapshot");
        xfer(1'b0, 0, 0, 16'h0, "R4 fresh snapshot");
        xfer(1'b0, 0, 3, 16'h0, "R4 top byte after fresh snapshot");

        // R9 R10: write one to clear
        xfer(1'b1, 0, 0, 16'h0001, "R9 clear byte 0");
        xfer(1'b1, 0, 1, 16'h0000, "R9 clear byte 1");
        xfer(1'b1, 0, 2, 16'h0000, "R9 clear byte 2");
        xfer(1'b1, 0, 3, 16'h0000, "R9 clear commit");
        chk(irq == 1'b0, "R10 irq low after clear", irq, 0);
        xfer(1'b0, 0, 0, 16'h0, "R9 cleared bit reads zero");
        xfer(1'b0, 0, 3, 16'h0, "R9 other bit kept");

        // R11: out-of-range index
        bus16 = 1'b1;
        xfer(1'b1, 20, 0, 16'hFFFF, "R11 write half 0");
        xfer(1'b1, 20, 1, 16'hFFFF, "R11 write commit");
        xfer(1'b0, 20, 0, 16'h0, "R11 out of range reads zero");
        xfer(1'b0, 20, 1, 16'h0, "R11 out of range reads zero");
        for (int k = 2; k < 8; k++) xfer(1'b0, k, 0, 16'h0, "R11 in-range registers untouched");

        running = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule